// File: doc/BRIEF.md
# Time-Match Alarm Interrupt Unit

This block holds two alarm channels next to a running calendar clock. Each channel keeps four match bytes (seconds, minutes, hours, day of week) in BCD. On every one-second tick, issued after the timekeeper has updated its fields, each channel compares its bytes with the current time. A channel whose fields all agree raises a pending flag. Bit 7 of any match byte turns that field into a wildcard.

A pending flag pulls an active-low interrupt line when its channel is enabled in the control register. A routing bit in the same register sends channel 1 either to its own line or onto the channel 0 line. Software acknowledges a channel in one of two ways. It can touch that channel's match registers, by reading or writing them. It can also write the status register with a 0 in that channel's bit.

The timekeeper is outside the block. It supplies the time bytes and the tick pulse.

Top module: `alm_irq_unit`

## Requirements
- R1: After reset every match byte, the control register and the status register read 0x00, and both `int0_n` and `int1_n` are high.
- R2: Channel c, field f (0 seconds, 1 minutes, 2 hours, 3 day of week) reads and writes at address 0x07+4c+f. The control register is at 0x0F with bit 0 enabling channel 0, bit 1 enabling channel 1 and bit 2 the routing select; its bits 7:3 read 0. The status register is at 0x10 with bit 0 the channel 0 flag and bit 1 the channel 1 flag, and its other bits read 0. Every other address reads 0x00.
- R3: A channel's flag is set at the clock edge where `tick` is high and all of its fields match. A match without `tick` sets nothing.
- R4: A match byte with bit 7 set always matches its field. Its other fields are still compared on bits 6:0.
- R5: The hour comparison covers bits 6:0, including bit 6 (12-hour mode) and bit 5 (PM), so an AM/PM difference prevents a match.
- R6: A flag is set on a match whether or not its enable bit is set. An interrupt line goes low only while a flag and its enable are both 1.
- R7: A read or write of any of a channel's four match addresses clears that channel's flag at that edge and leaves the other channel's flag alone.
- R8: A write to the status register clears each flag whose written bit is 0. A written 1 leaves the flag unchanged.
- R9: With the routing bit at 1, channel 1 drives `int1_n`. With it at 0, both channels drive `int0_n` and `int1_n` stays high.
- R10: An asserted interrupt line stays low over later non-matching ticks until its flag is cleared.
- R11: When a match on `tick` and a clear for the same channel (register touch or status write of 0) fall on one edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse marking a fresh time value |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hour, BCD with 12h/PM bits |
| now_wday | input | 8 | Current day of week |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, same cycle |
| int0_n | output | 1 | Active-low interrupt line 0 |
| int1_n | output | 1 | Active-low interrupt line 1 |

## Verification
A new match and an acknowledge of the same channel can land on the same clock edge. The acknowledge may come from a read of a match register or from a status write of 0. The bench forces both cases by raising `tick` with a fully wildcarded channel in the same cycle as the bus access. It then reads the status register, where the flag must be set. The checker states the same rule as a property on the match and flag signals.

// File: rtl/alm_pkg.sv
package alm_pkg;
    localparam int DW        = 8;
    localparam int AW        = 8;
    localparam int FIELDS    = 4;
    localparam int NUM_CH    = 2;
    localparam int ALM_BASE  = 7;
    localparam int CTRL_ADDR = ALM_BASE + NUM_CH * FIELDS;
    localparam int STAT_ADDR = CTRL_ADDR + 1;
    localparam int WILD_BIT  = DW - 1;

    typedef logic [FIELDS-1:0][DW-1:0] fieldset_t;

    typedef struct packed {
        logic route;
        logic en1;
        logic en0;
    } ctrl_t;

    typedef struct packed {
        logic          en;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } bus_req_t;

    function automatic logic field_hit(input logic [DW-1:0] pat,
                                       input logic [DW-1:0] now);
        return pat[WILD_BIT] || (pat[WILD_BIT-1:0] == now[WILD_BIT-1:0]);
    endfunction

    function automatic logic [AW-1:0] ch_addr(input int ch, input int fld);
        return AW'(ALM_BASE + ch * FIELDS + fld);
    endfunction

    function automatic logic in_channel(input logic [AW-1:0] addr, input int ch);
        return (addr >= ch_addr(ch, 0)) && (addr <= ch_addr(ch, FIELDS - 1));
    endfunction
endpackage

// File: rtl/alm_regs.sv
module alm_regs
    import alm_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  bus_req_t                      req,
    input  logic [NUM_CH-1:0]             flags,
    output logic [NUM_CH-1:0][FIELDS-1:0][DW-1:0] pats,
    output ctrl_t                         ctrl,
    output logic [DW-1:0]                 rdata,
    output logic [NUM_CH-1:0]             touch,
    output logic                          stat_wr,
    output logic [NUM_CH-1:0]             stat_bits
);
    localparam logic [AW-1:0] CTRL_A = AW'(CTRL_ADDR);
    localparam logic [AW-1:0] STAT_A = AW'(STAT_ADDR);
    localparam int CTRL_W = $bits(ctrl_t);

    logic wr_any;
    assign wr_any = req.en && req.we;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign touch[c] = req.en && in_channel(req.addr, c);
        for (genvar f = 0; f < FIELDS; f++) begin : g_fld
            always_ff @(posedge clk) begin
                if (rst) begin
                    pats[c][f] <= '0;
                end else if (wr_any && req.addr == ch_addr(c, f)) begin
                    pats[c][f] <= req.wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_any && req.addr == CTRL_A) begin
            ctrl <= ctrl_t'(req.wdata[CTRL_W-1:0]);
        end
    end

    assign stat_wr   = wr_any && (req.addr == STAT_A);
    assign stat_bits = req.wdata[NUM_CH-1:0];

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            for (int f = 0; f < FIELDS; f++) begin
                if (req.addr == ch_addr(c, f)) rdata = pats[c][f];
            end
        end
        if (req.addr == CTRL_A) rdata = DW'(ctrl);
        if (req.addr == STAT_A) rdata = DW'(flags);
    end
endmodule

// File: rtl/alm_match.sv
module alm_match
    import alm_pkg::*;
(
    input  fieldset_t pat,
    input  fieldset_t now,
    output logic      hit
);
    logic [FIELDS-1:0] fh;

    for (genvar f = 0; f < FIELDS; f++) begin : g_fld
        assign fh[f] = field_hit(pat[f], now[f]);
    end

    assign hit = &fh;
endmodule

// File: rtl/alm_flags.sv
module alm_flags
    import alm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [NUM_CH-1:0] hit,
    input  logic [NUM_CH-1:0] touch,
    input  logic              stat_wr,
    input  logic [NUM_CH-1:0] stat_bits,
    input  ctrl_t             ctrl,
    output logic [NUM_CH-1:0] flags,
    output logic              int0_n,
    output logic              int1_n
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_flag
        logic set_c, clr_c;
        assign set_c = tick && hit[c];
        assign clr_c = touch[c] || (stat_wr && !stat_bits[c]);
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[c] <= 1'b0;
            end else if (set_c) begin
                flags[c] <= 1'b1;
            end else if (clr_c) begin
                flags[c] <= 1'b0;
            end
        end
    end

    logic req0, req1;
    assign req0 = flags[0] && ctrl.en0;
    assign req1 = flags[1] && ctrl.en1;

    assign int0_n = !(req0 || (req1 && !ctrl.route));
    assign int1_n = !(req1 && ctrl.route);
endmodule

// File: rtl/alm_irq_unit.sv
module alm_irq_unit
    import alm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [7:0]    now_sec,
    input  logic [7:0]    now_min,
    input  logic [7:0]    now_hour,
    input  logic [7:0]    now_wday,
    input  logic          bus_en,
    input  logic          bus_we,
    input  logic [7:0]    bus_addr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    output logic          int0_n,
    output logic          int1_n
);
    bus_req_t                              req_w;
    fieldset_t                             now_w;
    logic [NUM_CH-1:0][FIELDS-1:0][DW-1:0] pats_w;
    ctrl_t                                 ctrl_w;
    logic [NUM_CH-1:0]                     touch_w;
    logic [NUM_CH-1:0]                     hit_w;
    logic [NUM_CH-1:0]                     flag_w;
    logic [NUM_CH-1:0]                     sbits_w;
    logic                                  swr_w;

    assign req_w = '{en: bus_en, we: bus_we, addr: bus_addr, wdata: bus_wdata};
    assign now_w = {now_wday, now_hour, now_min, now_sec};

    alm_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .req       (req_w),
        .flags     (flag_w),
        .pats      (pats_w),
        .ctrl      (ctrl_w),
        .rdata     (bus_rdata),
        .touch     (touch_w),
        .stat_wr   (swr_w),
        .stat_bits (sbits_w)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
        alm_match u_match (
            .pat (pats_w[c]),
            .now (now_w),
            .hit (hit_w[c])
        );
    end

    alm_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .hit       (hit_w),
        .touch     (touch_w),
        .stat_wr   (swr_w),
        .stat_bits (sbits_w),
        .ctrl      (ctrl_w),
        .flags     (flag_w),
        .int0_n    (int0_n),
        .int1_n    (int1_n)
    );
endmodule

// File: rtl/alm_irq_chk.sv
module alm_irq_chk
    import alm_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       bus_en,
    input logic       bus_we,
    input logic [7:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       int0_n,
    input logic       int1_n,
    input logic [1:0] hit,
    input logic [1:0] flag,
    input logic [2:0] ctrl_bits
);
    localparam logic [7:0] STAT_A = 8'(STAT_ADDR);

    logic acc0, sw_keep0;
    assign acc0     = bus_en && in_channel(bus_addr, 0);
    assign sw_keep0 = bus_en && bus_we && bus_addr == STAT_A && bus_wdata[0];

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (int0_n && int1_n)); // R1

    AST_SET_ON_MATCH0: assert property (@(posedge clk) disable iff (rst)
        (tick && hit[0]) |=> flag[0]); // R11

    AST_SET_ON_MATCH1: assert property (@(posedge clk) disable iff (rst)
        (tick && hit[1]) |=> flag[1]); // R3

    AST_NO_SET_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!flag[0] && !tick) |=> !flag[0]); // R3

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (acc0 && !(tick && hit[0])) |=> !flag[0]); // R7

    AST_STAT_ONE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (flag[0] && sw_keep0 && !acc0) |=> flag[0]); // R8

    AST_INT0_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (flag[0] && ctrl_bits[0]) |-> !int0_n); // R10

    AST_INT1_PARKED: assert property (@(posedge clk) disable iff (rst)
        !ctrl_bits[2] |-> int1_n); // R9
endmodule

bind alm_irq_unit alm_irq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .int0_n    (int0_n),
    .int1_n    (int1_n),
    .hit       (hit_w),
    .flag      (flag_w),
    .ctrl_bits (ctrl_w)
);

// File: tb/sim_alm_irq_unit.sv
module sim_alm_irq_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_wday = '0;
    logic       bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       int0_n, int1_n;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alm_irq_unit u0 (
        .clk(clk), .rst(rst), .tick(tick),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour), .now_wday(now_wday),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .int0_n(int0_n), .int1_n(int1_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic set_ch(input int ch, input logic [7:0] s, input logic [7:0] m,
                          input logic [7:0] h, input logic [7:0] w);
        wr(8'(7 + 4*ch), s);
        wr(8'(8 + 4*ch), m);
        wr(8'(9 + 4*ch), h);
        wr(8'(10 + 4*ch), w);
    endtask

    task automatic do_tick(input logic [7:0] s, input logic [7:0] m,
                           input logic [7:0] h, input logic [7:0] w);
        @(negedge clk);
        now_sec = s; now_min = m; now_hour = h; now_wday = w; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic pins(input string req, input logic e0, input logic e1);
        #1;
        chk(req, {6'b0, int1_n, int0_n}, {6'b0, e1, e0});
    endtask

    task automatic t_reset;
        logic [7:0] d;
        pins("R1 pins", 1'b1, 1'b1);
        for (int a = 7; a <= 16; a++) begin
            rd(8'(a), d);
            chk("R1 reset value", d, 8'h00);
        end
    endtask

    task automatic t_map;
        logic [7:0] d;
        for (int i = 0; i < 8; i++) wr(8'(7 + i), 8'(8'h11 * (i + 1)));
        for (int i = 0; i < 8; i++) begin
            rd(8'(7 + i), d);
            chk("R2 match byte readback", d, 8'(8'h11 * (i + 1)));
        end
        wr(8'h0F, 8'hF8);
        rd(8'h0F, d);
        chk("R2 control upper bits read 0", d, 8'h00);
        wr(8'h0F, 8'hFF);
        rd(8'h0F, d);
        chk("R2 control bits", d, 8'h07);
        rd(8'h11, d);
        chk("R2 unmapped", d, 8'h00);
        wr(8'h0F, 8'h00);
    endtask

    task automatic t_match;
        logic [7:0] d;
        set_ch(0, 8'h30, 8'h15, 8'h08, 8'h03);
        set_ch(1, 8'h59, 8'h59, 8'h23, 8'h07);
        wr(8'h10, 8'h00);
        @(negedge clk);
        now_sec = 8'h30; now_min = 8'h15; now_hour = 8'h08; now_wday = 8'h03;
        repeat (3) @(negedge clk);
        rd(8'h10, d);
        chk("R3 no tick no flag", d, 8'h00);
        do_tick(8'h30, 8'h15, 8'h08, 8'h03);
        rd(8'h10, d);
        chk("R3 match sets flag", d, 8'h01);
        pins("R6 flag without enable", 1'b1, 1'b1);
        wr(8'h0F, 8'h01);
        pins("R6 enabled line low", 1'b0, 1'b1);
        repeat (5) @(negedge clk);
        pins("R10 stays low", 1'b0, 1'b1);
        do_tick(8'h31, 8'h15, 8'h08, 8'h03);
        pins("R10 nonmatching tick", 1'b0, 1'b1);
        wr(8'h10, 8'h01);
        rd(8'h10, d);
        chk("R8 write one keeps", d, 8'h01);
        wr(8'h10, 8'h00);
        rd(8'h10, d);
        chk("R8 write zero clears", d, 8'h00);
        pins("R10 released after clear", 1'b1, 1'b1);
        wr(8'h0F, 8'h00);
    endtask

    task automatic t_wild;
        logic [7:0] d;
        set_ch(0, 8'h80, 8'h15, 8'h08, 8'h80);
        set_ch(1, 8'h59, 8'h59, 8'h23, 8'h07);
        do_tick(8'h47, 8'h15, 8'h08, 8'h05);
        rd(8'h10, d);
        chk("R4 wildcard fields match", d, 8'h01);
        wr(8'h10, 8'h00);
        do_tick(8'h47, 8'h16, 8'h08, 8'h05);
        rd(8'h10, d);
        chk("R4 other fields still compared", d, 8'h00);
    endtask

    task automatic t_hour12;
        logic [7:0] d;
        set_ch(0, 8'h80, 8'h80, 8'h48, 8'h80);
        do_tick(8'h00, 8'h00, 8'h68, 8'h01);
        rd(8'h10, d);
        chk("R5 PM bit differs", d, 8'h00);
        do_tick(8'h00, 8'h00, 8'h08, 8'h01);
        rd(8'h10, d);
        chk("R5 12h bit differs", d, 8'h00);
        do_tick(8'h00, 8'h00, 8'h48, 8'h01);
        rd(8'h10, d);
        chk("R5 exact hour code", d, 8'h01);
        wr(8'h10, 8'h00);
    endtask

    task automatic t_ack;
        logic [7:0] d;
        set_ch(0, 8'h80, 8'h80, 8'h80, 8'h80);
        set_ch(1, 8'h80, 8'h80, 8'h80, 8'h80);
        do_tick(8'h12, 8'h34, 8'h05, 8'h02);
        rd(8'h10, d);
        chk("R7 both set", d, 8'h03);
        rd(8'h0C, d);
        rd(8'h10, d);
        chk("R7 read ch1 byte clears ch1 only", d, 8'h01);
        wr(8'h09, 8'h80);
        rd(8'h10, d);
        chk("R7 write ch0 byte clears ch0", d, 8'h00);
    endtask

    task automatic t_route;
        logic [7:0] d;
        wr(8'h0F, 8'h03);
        do_tick(8'h01, 8'h02, 8'h03, 8'h04);
        pins("R9 shared line", 1'b0, 1'b1);
        wr(8'h10, 8'h02);
        rd(8'h10, d);
        chk("R8 mixed status write", d, 8'h02);
        pins("R9 ch1 alone on line 0", 1'b0, 1'b1);
        wr(8'h0F, 8'h07);
        pins("R9 ch1 on own line", 1'b1, 1'b0);
        wr(8'h0F, 8'h05);
        pins("R6 ch1 disabled", 1'b1, 1'b1);
        wr(8'h10, 8'h00);
        wr(8'h0F, 8'h00);
    endtask

    task automatic t_collide;
        logic [7:0] d;
        set_ch(0, 8'h80, 8'h80, 8'h80, 8'h80);
        set_ch(1, 8'h59, 8'h59, 8'h23, 8'h07);
        @(negedge clk);
        now_sec = 8'h00; now_min = 8'h00; now_hour = 8'h00; now_wday = 8'h01;
        tick = 1'b1; bus_en = 1'b1; bus_we = 1'b0; bus_addr = 8'h07;
        @(negedge clk);
        tick = 1'b0; bus_en = 1'b0;
        rd(8'h10, d);
        chk("R11 match beats register touch", d, 8'h01);
        @(negedge clk);
        tick = 1'b1; bus_en = 1'b1; bus_we = 1'b1; bus_addr = 8'h10; bus_wdata = 8'h00;
        @(negedge clk);
        tick = 1'b0; bus_en = 1'b0; bus_we = 1'b0;
        rd(8'h10, d);
        chk("R11 match beats status clear", d, 8'h01);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_map();
        t_match();
        t_wild();
        t_hour12();
        t_ack();
        t_route();
        t_collide();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end
endmodule